// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block holds the digital side of a 12-bit successive-approximation converter. It drives a trial code into an external reference DAC and reads back one comparator bit. It then builds the conversion result one bit at a time, starting at the most significant bit. When all bits are decided it publishes the code and raises an end-of-convert flag. The rising edge of that flag is the moment a consumer should capture the result.

A conversion is requested by a rising edge on `start_in`. This input may come from another clock domain, so it is synchronized and edge-detected inside the block. A new rising edge starts the walk again from the top bit at any moment, even in the middle of a conversion, and needs no clear first. The `clear_in` input is synchronous to `clk`. It empties the conversion registers and aborts any walk in progress. The comparator bit `cmp_hi` is 1 when the analog input is at or above the trial code.

Top module: `sar_sequencer`

## Requirements
- R1: The trial code and the result are both `RES_BITS` wide (12 by default). With an ideal comparator (`cmp_hi` = input code >= trial code), the result equals the input code for every code from 0 to 4095.
- R2: Let k be the first rising `clk` edge that samples `start_in` high after it was low. At edge k+2, `trial_code` becomes 12'h800: only the most significant bit is set.
- R3: At each of the 12 edges k+3 through k+14, the bit under test is decided, from bit 11 down to bit 0. The bit is kept when `cmp_hi` is 1 and cleared when it is 0. At the same edge, the next lower bit is set as the new trial bit.
- R4: `eoc` rises at edge k+15, which is one edge after the last bit decision. In the same edge, `result` takes the final code. `eoc` stays low from edge k+2 through edge k+14.
- R5: `eoc` falls at edge k+2, the edge where a new conversion loads its first trial code.
- R6: A fresh rising edge on `start_in` during a conversion restarts the walk, with the same timing as in R2 through R4 and no clear needed. Holding `start_in` high starts exactly one conversion.
- R7: When `clear_in` is high at an edge, that edge sets `trial_code`, `result` and `eoc` to 0 and aborts any conversion. A start edge that arrives at a clearing edge is dropped.
- R8: `result` and `eoc` keep their values until the next conversion completes, a clear, or a reset. Changes on `cmp_hi` outside a conversion have no effect on them or on `trial_code`.
- R9: The synchronous active-high `rst` sets `trial_code`, `result` and `eoc` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| start_in | input | 1 | Conversion request; its rising edge starts a conversion; may be asynchronous |
| clear_in | input | 1 | Synchronous clear of the conversion registers |
| cmp_hi | input | 1 | Comparator bit; 1 when the analog input is at or above the trial code |
| trial_code | output | RES_BITS | Registered code for the reference DAC |
| result | output | RES_BITS | Last completed conversion result |
| eoc | output | 1 | End of convert; high while `result` holds a finished conversion |

## Verification
Two situations are hard to reach from the ports, because the start path has two cycles of synchronizer latency. The first is a start edge arriving in the middle of a walk. The second is a start edge whose internal pulse lands on a clearing edge. The bench drives every input at the falling clock edge and counts edges from the first edge that samples the request. This lets it place a second request after a known number of decisions, and hold `clear_in` across the exact edge where the synchronized pulse appears. An exhaustive sweep over all 4096 input codes, with an ideal comparator modelled in the bench, covers every path through the bit decisions.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    SAR_IDLE   = 2'd0,
    SAR_WALK   = 2'd1,
    SAR_SETTLE = 2'd2
  } sar_state_t;

endpackage

// File: rtl/sar_start_sync.sv
module sar_start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic go
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q[0] <= 1'b0;
    end else begin
      chain_q[0] <= req_async;
    end
  end

  genvar g;
  generate
    for (g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q[g] <= 1'b0;
        end else begin
          chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= 1'b0;
    end else begin
      last_q <= chain_q[LAST];
    end
  end

  assign go = chain_q[LAST] & ~last_q;

endmodule

// File: rtl/sar_bit_walker.sv
module sar_bit_walker
  import sar_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         go,
  input  logic         cmp_hi,
  output logic [W-1:0] trial,
  output logic         done
);

  localparam int            IW      = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] TOP_IDX = IW'(W - 1);
  localparam logic [W-1:0]  MSB_ONE = {1'b1, {(W-1){1'b0}}};

  sar_state_t    state_q;
  logic [IW-1:0] idx_q;
  logic [W-1:0]  trial_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state_q <= SAR_IDLE;
      idx_q   <= '0;
      trial_q <= '0;
    end else if (go) begin
      state_q <= SAR_WALK;
      idx_q   <= TOP_IDX;
      trial_q <= MSB_ONE;
    end else begin
      case (state_q)
        SAR_WALK: begin
          trial_q[idx_q] <= cmp_hi;
          if (idx_q != '0) begin
            trial_q[idx_q - 1'b1] <= 1'b1;
            idx_q                 <= idx_q - 1'b1;
          end else begin
            state_q <= SAR_SETTLE;
          end
        end
        SAR_SETTLE: state_q <= SAR_IDLE;
        default:    state_q <= SAR_IDLE;
      endcase
    end
  end

  assign trial = trial_q;
  assign done  = (state_q == SAR_SETTLE);

endmodule

// File: rtl/sar_result_hold.sv
module sar_result_hold #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         go,
  input  logic         done,
  input  logic [W-1:0] trial,
  output logic [W-1:0] result,
  output logic         eoc
);

  logic [W-1:0] result_q;
  logic         eoc_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      result_q <= '0;
      eoc_q    <= 1'b0;
    end else if (go) begin
      eoc_q    <= 1'b0;
    end else if (done) begin
      result_q <= trial;
      eoc_q    <= 1'b1;
    end
  end

  assign result = result_q;
  assign eoc    = eoc_q;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES_BITS    = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_in,
  input  logic                clear_in,
  input  logic                cmp_hi,
  output logic [RES_BITS-1:0] trial_code,
  output logic [RES_BITS-1:0] result,
  output logic                eoc
);

  logic                go_w;
  logic                done_w;
  logic [RES_BITS-1:0] trial_w;

  sar_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .req_async (start_in),
    .go        (go_w)
  );

  sar_bit_walker #(.W(RES_BITS)) u_walk (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear_in),
    .go     (go_w),
    .cmp_hi (cmp_hi),
    .trial  (trial_w),
    .done   (done_w)
  );

  sar_result_hold #(.W(RES_BITS)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .clear  (clear_in),
    .go     (go_w),
    .done   (done_w),
    .trial  (trial_w),
    .result (result),
    .eoc    (eoc)
  );

  assign trial_code = trial_w;

endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst,
  input logic         clear_in,
  input logic         go,
  input logic [W-1:0] trial_code,
  input logic [W-1:0] result,
  input logic         eoc
);

  localparam logic [W-1:0] MSB_ONE = {1'b1, {(W-1){1'b0}}};

  // R2: an accepted start loads only the top bit
  a_r2_load_msb: assert property (@(posedge clk) disable iff (rst)
    (go && !clear_in) |=> (trial_code == MSB_ONE));

  // R5: an accepted start drops end-of-convert
  a_r5_eoc_drops: assert property (@(posedge clk) disable iff (rst)
    (go && !clear_in) |=> !eoc);

  // R7: clear empties the conversion registers
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clear_in |=> (trial_code == '0 && result == '0 && !eoc));

  // R4: the published result matches the final trial code
  a_r4_result_match: assert property (@(posedge clk) disable iff (rst)
    $rose(eoc) |-> (result == trial_code));

  // R8: result only moves on completion or clear
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(result) |-> ($rose(eoc) || $past(clear_in)));

endmodule

bind sar_sequencer sar_sequencer_chk #(.W(RES_BITS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clear_in   (clear_in),
  .go         (go_w),
  .trial_code (trial_code),
  .result     (result),
  .eoc        (eoc)
);

// File: tb/sim_sar_sequencer.sv
`timescale 1ns/1ps
module sim_sar_sequencer;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_in = 1'b0;
  logic         clear_in = 1'b0;
  logic         ovr_en = 1'b0;
  logic         ovr_val = 1'b0;
  logic [W-1:0] vin = '0;
  logic         cmp_hi;
  logic [W-1:0] trial_code;
  logic [W-1:0] result;
  logic         eoc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  // ideal comparator model, with an override for the idle-noise test
  assign cmp_hi = ovr_en ? ovr_val : (vin >= trial_code);

  sar_sequencer #(.RES_BITS(W), .SYNC_STAGES(2)) u0 (
    .clk        (clk),
    .rst        (rst),
    .start_in   (start_in),
    .clear_in   (clear_in),
    .cmp_hi     (cmp_hi),
    .trial_code (trial_code),
    .result     (result),
    .eoc        (eoc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // raise start at a falling edge, then land after edge k+2
  task automatic begin_conv(input logic [W-1:0] v);
    vin      = v;
    start_in = 1'b1;
    @(negedge clk);               // after k
    @(negedge clk);               // after k+1
    @(negedge clk);               // after k+2
    check("R2 trial loads MSB", 32'(trial_code), 32'h800);
    check("R5 eoc falls on load", 32'(eoc), 32'd0);
    start_in = 1'b0;
  endtask

  task automatic finish_conv(input logic [W-1:0] v);
    repeat (12) @(negedge clk);   // after k+14
    check("R4 eoc low before last edge", 32'(eoc), 32'd0);
    @(negedge clk);               // after k+15
    check("R4 eoc rises", 32'(eoc), 32'd1);
    check("R1 R3 result equals input", 32'(result), 32'(v));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 trial after reset", 32'(trial_code), 32'd0);
    check("R9 result after reset", 32'(result), 32'd0);
    check("R9 eoc after reset", 32'(eoc), 32'd0);

    // R1 R3 R4: every input code
    for (int v = 0; v < (1 << W); v++) begin
      begin_conv(W'(v));
      finish_conv(W'(v));
    end

    // R8: comparator noise while idle leaves outputs alone
    ovr_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      ovr_val = i[0];
      @(negedge clk);
    end
    ovr_en = 1'b0;
    check("R8 result held", 32'(result), 32'hFFF);
    check("R8 trial held", 32'(trial_code), 32'hFFF);
    check("R8 eoc held", 32'(eoc), 32'd1);

    // R6: restart in the middle of a walk
    begin_conv(12'h5A3);
    repeat (4) @(negedge clk);
    begin_conv(12'h2C7);
    finish_conv(12'h2C7);

    // R6: a held start runs once
    vin      = 12'h3E1;
    start_in = 1'b1;
    repeat (18) @(negedge clk);
    check("R6 held start completes", 32'(result), 32'h3E1);
    vin = 12'h111;
    repeat (30) @(negedge clk);
    check("R6 no retrigger eoc", 32'(eoc), 32'd1);
    check("R6 no retrigger result", 32'(result), 32'h3E1);
    start_in = 1'b0;
    repeat (4) @(negedge clk);

    // R7: clear aborts a conversion
    begin_conv(12'hABC);
    repeat (3) @(negedge clk);
    clear_in = 1'b1;
    @(negedge clk);
    clear_in = 1'b0;
    check("R7 clear trial", 32'(trial_code), 32'd0);
    check("R7 clear result", 32'(result), 32'd0);
    check("R7 clear eoc", 32'(eoc), 32'd0);
    repeat (20) @(negedge clk);
    check("R7 aborted stays low", 32'(eoc), 32'd0);

    // R7: start edge landing while clear is high is dropped
    begin_conv(12'h0F0);
    finish_conv(12'h0F0);
    vin      = 12'h777;
    start_in = 1'b1;
    clear_in = 1'b1;
    repeat (4) @(negedge clk);
    clear_in = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 dropped start eoc", 32'(eoc), 32'd0);
    check("R7 dropped start result", 32'(result), 32'd0);
    start_in = 1'b0;
    repeat (4) @(negedge clk);

    // R9: reset mid conversion
    begin_conv(12'h9D2);
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9 reset trial", 32'(trial_code), 32'd0);
    repeat (20) @(negedge clk);
    check("R9 reset aborts", 32'(eoc), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule